// File: doc/BRIEF.md
# PRBS Link Self-Test Engine

This block exercises a 64-bit-per-cycle serial-link datapath without any outside traffic source. A generator sends a PRBS-31 stream onto the transmit side, one 64-bit line per beat. A programmable rate word throttles the stream to a fixed fraction of clock cycles. A checker on the receive side locks onto whatever PRBS stream comes back. It counts received lines in blocks of 65536, counts lines that differ from the predicted value, and measures how long the first line of a run takes to travel from the transmit port to the receive port.

In normal use, software or a test sequencer enables both halves and lets the run go for a while. It then switches the generator off and leaves the checker on, so that lines still in flight are drained and checked. It then reads the lock flag, latency and counters. Dropping the checker enable clears all checker results. Dropping the generator enable restarts the sequence and the throttle.

Top module: `link_bist_top`

## Requirements
- R1: Each transmitted line is 64 bits of the PRBS-31 sequence x^31+x^28+1, newest bit in bit 0. A line is produced by shifting a 31-bit state 64 times; each new bit is state[30] XOR state[27] and is shifted in at the bottom. The state after a line equals the line's bits [30:0]. The first line after the generator is enabled uses the state SEED.
- R2: With rate word r, on the k-th consecutive cycle in which the generator is enabled (k counted from 1), tx_valid_o is high in the following cycle exactly when floor(k*(r+1)/64) exceeds floor((k-1)*(r+1)/64). This gives exactly r+1 lines in any 64 consecutive enabled cycles, and every cycle when r=63.
- R3: The two enables act independently. The cycle after gen_en_i falls, tx_valid_o is low. The checker keeps its lock and keeps checking and counting any lines that still arrive.
- R4: Lock acquisition works as follows. A received line that is not a predicted match reseeds the checker from its bits [30:0]. locked_o rises in the cycle after the fourth consecutive received line that matches the prediction made from the line before it.
- R5: latency_o gives D/16, rounded down, where D is the number of cycles from the cycle in which the first line of a generator run is on the transmit port to the cycle in which a line with that same value is on the receive port. It updates the cycle after the arrival and saturates at 0xFFFF.
- R6: samp_cnt_o increments once for every 65536 valid lines received while the checker is enabled.
- R7: Once locked, the checker advances its own prediction independently of the received data. Each mismatching line adds one to err_cnt_o, and lock is kept. No error is counted before lock.
- R8: The cycle after chk_en_i is low, locked_o, latency_o, samp_cnt_o and err_cnt_o are all zero. Re-enabling the generator restarts the sequence at SEED.
- R9: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_en_i | input | 1 | Checker enable |
| gen_en_i | input | 1 | Generator enable |
| rate_i | input | 6 | Rate word r; r+1 lines per 64 cycles |
| tx_valid_o | output | 1 | Transmit line valid |
| tx_data_o | output | 64 | Transmit line |
| rx_valid_i | input | 1 | Receive line valid |
| rx_data_i | input | 64 | Receive line |
| locked_o | output | 1 | Checker locked to the incoming sequence |
| latency_o | output | 16 | Round-trip latency in units of 16 cycles |
| samp_cnt_o | output | 32 | Received lines divided by 65536, saturating |
| err_cnt_o | output | 32 | Mismatching lines since lock, saturating |

## Verification
Each result has a fixed delay after its stimulus:

- A transmit line is visible one cycle after the enabled edge that produces its beat.
- Lock, both counters and latency are all registered. Each shows the effect of a received line in the cycle after the edge that samples that line.
- Clearing through chk_en_i is visible one cycle later.

The bench drives inputs and samples outputs on the falling edge. A behavioural model is updated on the rising edge from the same inputs, so every compare sees DUT and model one register stage after the same edge. Loopback delays of 0 and 37 cycles are built in a bench queue. The targeted checks are placed at a known number of cycles after each stimulus.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  localparam int unsigned LINE_W = 64;
  localparam int unsigned PRBS_W = 31;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [PRBS_W-1:0] prbs_t;

  // 64 serial steps of x^31+x^28+1, newest bit lands in bit 0
  function automatic line_t prbs_line(input prbs_t st);
    line_t w;
    prbs_t s;
    logic  b;
    s = st;
    w = '0;
    for (int i = 0; i < LINE_W; i++) begin
      b = s[PRBS_W-1] ^ s[PRBS_W-4];
      s = {s[PRBS_W-2:0], b};
      w[LINE_W-1-i] = b;
    end
    return w;
  endfunction
endpackage

// File: rtl/link_bist_throttle.sv
module link_bist_throttle #(
  parameter int unsigned RATE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              beat_o
);
  localparam int unsigned SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum    = SUM_W'(acc_q) + SUM_W'(rate_i) + SUM_W'(1);
  assign beat_o = en_i & sum[RATE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[RATE_W-1:0];
  end

  assert_acc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);
endmodule

// File: rtl/link_bist_gen.sv
module link_bist_gen
  import link_bist_pkg::*;
#(
  parameter prbs_t SEED = 31'h2A5A_5A5A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  beat_i,
  output logic  tx_valid_o,
  output line_t tx_data_o,
  output logic  tx_first_o
);
  prbs_t state_q;
  logic  pend_q;
  line_t nxt;

  assign nxt = prbs_line(state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEED;
      pend_q     <= 1'b1;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_first_o <= 1'b0;
    end else if (!en_i) begin
      state_q    <= SEED;
      pend_q     <= 1'b1;
      tx_valid_o <= 1'b0;
      tx_first_o <= 1'b0;
    end else begin
      tx_valid_o <= beat_i;
      if (beat_i) begin
        tx_data_o  <= nxt;
        state_q    <= nxt[PRBS_W-1:0];
        tx_first_o <= pend_q;
        pend_q     <= 1'b0;
      end
    end
  end

  assert_gen_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tx_valid_o);
  assert_restart_seed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == SEED);
endmodule

// File: rtl/link_bist_chk.sv
module link_bist_chk
  import link_bist_pkg::*;
#(
  parameter int unsigned LOCK_RUN   = 4,
  parameter int unsigned SAMP_SHIFT = 16,
  parameter int unsigned CNT_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_valid_i,
  input  line_t            rx_data_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] samp_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic                  seeded_q;
  logic [RUN_W-1:0]      run_q;
  prbs_t                 exp_q;
  logic [SAMP_SHIFT-1:0] line_q;
  line_t                 exp_line;
  logic                  hit;

  assign exp_line = prbs_line(exp_q);
  assign hit      = (rx_data_i == exp_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q   <= 1'b0;
      run_q      <= '0;
      exp_q      <= '0;
      line_q     <= '0;
      locked_o   <= 1'b0;
      samp_cnt_o <= '0;
      err_cnt_o  <= '0;
    end else if (!en_i) begin
      seeded_q   <= 1'b0;
      run_q      <= '0;
      line_q     <= '0;
      locked_o   <= 1'b0;
      samp_cnt_o <= '0;
      err_cnt_o  <= '0;
    end else if (rx_valid_i) begin
      line_q <= line_q + 1'b1;
      if (&line_q && !(&samp_cnt_o)) samp_cnt_o <= samp_cnt_o + 1'b1;
      if (locked_o) begin
        // free-run: a corrupted line costs exactly one error
        exp_q <= exp_line[PRBS_W-1:0];
        if (!hit && !(&err_cnt_o)) err_cnt_o <= err_cnt_o + 1'b1;
      end else if (seeded_q && hit) begin
        exp_q <= rx_data_i[PRBS_W-1:0];
        run_q <= run_q + 1'b1;
        if (run_q == RUN_W'(LOCK_RUN - 1)) locked_o <= 1'b1;
      end else begin
        exp_q    <= rx_data_i[PRBS_W-1:0];
        seeded_q <= 1'b1;
        run_q    <= '0;
      end
    end
  end

  assert_lock_needs_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(rx_valid_i));
  assert_no_err_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !locked_o) |=> $stable(err_cnt_o));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!locked_o && samp_cnt_o == '0 && err_cnt_o == '0));
endmodule

// File: rtl/link_bist_lat.sv
module link_bist_lat
  import link_bist_pkg::*;
#(
  parameter int unsigned LAT_W     = 16,
  parameter int unsigned LAT_SHIFT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tx_valid_i,
  input  logic             tx_first_i,
  input  line_t            tx_data_i,
  input  logic             rx_valid_i,
  input  line_t            rx_data_i,
  output logic [LAT_W-1:0] latency_o
);
  localparam int unsigned CW = LAT_W + LAT_SHIFT;

  logic [CW-1:0] cnt_q;
  logic          act_q;
  line_t         mark_q;
  logic          start, same, back;

  assign start = tx_valid_i & tx_first_i;
  assign same  = rx_valid_i & (rx_data_i == tx_data_i);
  assign back  = rx_valid_i & (rx_data_i == mark_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_q     <= 1'b0;
      mark_q    <= '0;
      latency_o <= '0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      act_q     <= 1'b0;
      latency_o <= '0;
    end else if (start) begin
      mark_q <= tx_data_i;
      cnt_q  <= CW'(1);
      act_q  <= !same;
      if (same) latency_o <= '0;
    end else if (act_q) begin
      if (back) begin
        latency_o <= cnt_q[CW-1:LAT_SHIFT];
        act_q     <= 1'b0;
      end else if (!(&cnt_q)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_lat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> latency_o == '0);
  assert_lat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start && !act_q) |=> $stable(latency_o));
endmodule

// File: rtl/link_bist_top.sv
module link_bist_top
  import link_bist_pkg::*;
#(
  parameter int unsigned RATE_W     = 6,
  parameter int unsigned LOCK_RUN   = 4,
  parameter int unsigned SAMP_SHIFT = 16,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned LAT_W      = 16,
  parameter int unsigned LAT_SHIFT  = 4,
  parameter prbs_t       SEED       = 31'h2A5A_5A5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_en_i,
  input  logic              gen_en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tx_valid_o,
  output logic [LINE_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [LINE_W-1:0] rx_data_i,
  output logic              locked_o,
  output logic [LAT_W-1:0]  latency_o,
  output logic [CNT_W-1:0]  samp_cnt_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic beat;
  logic tx_first;

  link_bist_throttle #(.RATE_W(RATE_W)) u_thr (
    .clk_i, .rst_ni, .en_i(gen_en_i), .rate_i, .beat_o(beat)
  );

  link_bist_gen #(.SEED(SEED)) u_gen (
    .clk_i, .rst_ni, .en_i(gen_en_i), .beat_i(beat),
    .tx_valid_o, .tx_data_o, .tx_first_o(tx_first)
  );

  link_bist_chk #(.LOCK_RUN(LOCK_RUN), .SAMP_SHIFT(SAMP_SHIFT), .CNT_W(CNT_W)) u_chk (
    .clk_i, .rst_ni, .en_i(chk_en_i), .rx_valid_i, .rx_data_i,
    .locked_o, .samp_cnt_o, .err_cnt_o
  );

  link_bist_lat #(.LAT_W(LAT_W), .LAT_SHIFT(LAT_SHIFT)) u_lat (
    .clk_i, .rst_ni, .en_i(chk_en_i),
    .tx_valid_i(tx_valid_o), .tx_first_i(tx_first), .tx_data_i(tx_data_o),
    .rx_valid_i, .rx_data_i, .latency_o
  );

  assert_full_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_en_i && (&rate_i)) |=> tx_valid_o);
  assert_tx_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> !tx_valid_o);
endmodule

// File: tb/link_bist_top_tb_top.sv
module link_bist_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [30:0] SEED = 31'h2A5A_5A5A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        chk_en = 1'b0, gen_en = 1'b0;
  logic [5:0]  rate = '0;
  logic        tx_valid_o;
  logic [63:0] tx_data_o;
  logic        rx_valid = 1'b0;
  logic [63:0] rx_data = '0;
  logic        locked_o;
  logic [15:0] latency_o;
  logic [31:0] samp_cnt_o, err_cnt_o;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;
  int garbage_n = 0, corrupt_n = 0;
  logic [64:0] dq[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_bist_top dut_i (
    .clk_i, .rst_ni, .chk_en_i(chk_en), .gen_en_i(gen_en), .rate_i(rate),
    .tx_valid_o, .tx_data_o, .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .locked_o, .latency_o, .samp_cnt_o, .err_cnt_o
  );

  function automatic logic [63:0] ref_line(input logic [30:0] st);
    logic [63:0] w;
    logic [30:0] s;
    s = st;
    for (int i = 63; i >= 0; i--) begin
      w[i] = s[30] ^ s[27];
      s = {s[29:0], w[i]};
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model
  int          m_k = 0, m_run = 0, m_lines = 0, m_cnt = 0;
  logic [30:0] m_st = SEED, m_exp = '0;
  logic        m_txv = 0, m_first = 0, m_pend = 1, m_seeded = 0, m_lock = 0, m_act = 0;
  logic [63:0] m_txd = '0, m_mark = '0, e;
  longint      m_samp = 0, m_err = 0, m_lat = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_k = 0; m_st = SEED; m_txv = 0; m_first = 0; m_pend = 1; m_txd = '0;
      m_seeded = 0; m_run = 0; m_lock = 0; m_lines = 0; m_samp = 0; m_err = 0;
      m_act = 0; m_cnt = 0; m_lat = 0; m_mark = '0;
    end else begin
      if (!chk_en) begin
        m_lat = 0; m_act = 0; m_cnt = 0;
      end else if (m_txv && m_first) begin
        m_mark = m_txd;
        if (rx_valid && rx_data == m_txd) begin m_lat = 0; m_act = 0; end
        else begin m_act = 1; m_cnt = 1; end
      end else if (m_act) begin
        if (rx_valid && rx_data == m_mark) begin m_lat = m_cnt / 16; m_act = 0; end
        else if (m_cnt < 1048575) m_cnt++;
      end
      if (!chk_en) begin
        m_seeded = 0; m_run = 0; m_lock = 0; m_lines = 0; m_samp = 0; m_err = 0;
      end else if (rx_valid) begin
        m_lines++;
        if (m_lines == 65536) begin m_lines = 0; m_samp++; end
        e = ref_line(m_exp);
        if (m_lock) begin
          if (rx_data != e) m_err++;
          m_exp = e[30:0];
        end else if (m_seeded && rx_data == e) begin
          m_run++; m_exp = rx_data[30:0];
          if (m_run == 4) m_lock = 1;
        end else begin
          m_seeded = 1; m_run = 0; m_exp = rx_data[30:0];
        end
      end
      if (!gen_en) begin
        m_k = 0; m_st = SEED; m_txv = 0; m_pend = 1; m_first = 0;
      end else begin
        m_k++;
        m_txv = ((m_k * (rate + 1)) / 64) != (((m_k - 1) * (rate + 1)) / 64);
        if (m_txv) begin
          m_txd = ref_line(m_st); m_st = m_txd[30:0];
          m_first = m_pend; m_pend = 0;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_on && !done) begin
      check("R2 tx_valid", 64'(tx_valid_o), 64'(m_txv));
      if (m_txv) check("R1 tx_data", tx_data_o, m_txd);
      check("R4 locked", 64'(locked_o), 64'(m_lock));
      check("R5 latency", 64'(latency_o), 64'(m_lat));
      check("R6 samples", 64'(samp_cnt_o), 64'(m_samp));
      check("R7 errors", 64'(err_cnt_o), 64'(m_err));
    end
  end

  // loopback with programmable delay, optional garbage and corruption
  always @(negedge clk_i) begin
    logic [64:0] ent;
    dq.push_back({tx_valid_o, tx_data_o});
    ent = dq.pop_front();
    if (garbage_n > 0) begin
      rx_valid = 1'b1; rx_data = {$urandom, $urandom}; garbage_n--;
    end else begin
      rx_valid = ent[64]; rx_data = ent[63:0];
      if (ent[64] && corrupt_n > 0) begin rx_data[5] = ~rx_data[5]; corrupt_n--; end
    end
  end

  task automatic set_delay(input int d);
    dq.delete();
    for (int i = 0; i < d; i++) dq.push_back('0);
  endtask

  task automatic window_count(input int exp, input string req);
    int c = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk_i); c += int'(tx_valid_o); end
    check(req, 64'(c), 64'(exp));
  endtask

  task automatic wait_first(input string req);
    int t = 0;
    do begin @(negedge clk_i); t++; end while (!tx_valid_o && t < 100);
    check(req, tx_data_o, ref_line(SEED));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] e0;
    set_delay(0);
    repeat (3) @(negedge clk_i);
    check("R9 reset tx_valid", 64'(tx_valid_o), 0);
    check("R9 reset outputs", 64'({locked_o, latency_o, samp_cnt_o, err_cnt_o}), 0);
    rst_ni = 1'b1;
    cmp_on = 1;

    // full rate, zero delay
    rate = 6'd63; chk_en = 1; gen_en = 1;
    wait_first("R1 first line from seed");
    repeat (20) @(negedge clk_i);
    check("R4 locked at full rate", 64'(locked_o), 1);
    check("R5 zero-delay latency", 64'(latency_o), 0);
    corrupt_n = 3;
    repeat (20) @(negedge clk_i);
    check("R7 three corrupted lines", 64'(err_cnt_o), 3);
    check("R7 lock kept", 64'(locked_o), 1);
    gen_en = 0; chk_en = 0;
    @(negedge clk_i);
    check("R8 cleared", 64'({locked_o, latency_o, samp_cnt_o, err_cnt_o}), 0);
    check("R3 tx idle", 64'(tx_valid_o), 0);

    // mid rate, 37-cycle loop, garbage before the stream
    set_delay(37); rate = 6'd21; garbage_n = 6; chk_en = 1; gen_en = 1;
    repeat (10) @(negedge clk_i);
    window_count(22, "R2 22 lines per 64 cycles");
    repeat (300) @(negedge clk_i);
    check("R4 locked after garbage", 64'(locked_o), 1);
    check("R5 latency 37/16", 64'(latency_o), 2);
    e0 = err_cnt_o;
    gen_en = 0; corrupt_n = 1;
    repeat (45) @(negedge clk_i);
    check("R3 tx idle after gen off", 64'(tx_valid_o), 0);
    check("R3 drained line still checked", 64'(err_cnt_o), 64'(e0 + 1));
    check("R3 lock kept", 64'(locked_o), 1);
    chk_en = 0;
    @(negedge clk_i);

    // slowest rate, restart from seed
    set_delay(0); rate = 6'd0; chk_en = 1; gen_en = 1;
    wait_first("R8 restart at seed");
    window_count(1, "R2 one line per 64 cycles");
    gen_en = 0; chk_en = 0;
    @(negedge clk_i);

    // sample counter
    rate = 6'd63; chk_en = 1; gen_en = 1;
    repeat (65600) @(negedge clk_i);
    check("R6 one sample block", 64'(samp_cnt_o), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule